// File: doc/BRIEF.md
# Banked General Register File

This block is the register storage of a small 8/16-bit processor core. It keeps four banks of eight byte-wide general registers, where the active bank is picked by two bank-select bits of the status word. A single write port and a single read port address registers through a 5-bit selector. The selector picks an individual byte register, a 16-bit register pair built from two of those bytes, or one of the special registers: status word, stack pointer, two segment bytes, a mode byte and a memory-bank byte.

All 32 general bytes are also visible through a flat byte-addressed window port, as if they were mapped into data memory. The banks lie in that window in reverse order, so bank 0 takes the top eight bytes. A branch-condition evaluator turns the carry and zero flags of the status word, or a supplied test value, into a single taken/not-taken bit. Every output is registered and updates on the clock edge after its inputs are presented.

Top module: `bank_regfile`

## Requirements
- R1: On synchronous reset every general byte reads 0x11, the status word reads 0x06, the ES segment byte reads 0x0F, the CS segment byte, mode byte and memory-bank byte read 0x00, and the stack pointer reads 0x0000.
- R2: Selector codes X=1, A=2, C=3, B=4, E=5, D=6, L=7, H=8 address single byte registers of the active bank, which sit at in-bank positions X=0, A=1, C=2, B=3, E=4, D=5, L=6, H=7. A byte write stores wr_data[7:0]. A byte read returns the byte zero-extended on rd_data one cycle after rd_sel is presented.
- R3: Pair codes AX=9, BC=10, DE=11, HL=12 read as high*256+low (A:X, B:C, D:E, H:L). A pair write stores wr_data[15:8] in the high byte and wr_data[7:0] in the low byte.
- R4: The active bank is status bit 5 times 2 plus status bit 3. A status write (code 14) changes the bank used by accesses only from the following cycle.
- R5: Window byte address (3-n)*8 + position reaches register position of bank n. win_rdata returns the addressed byte one cycle later, and a window write (win_we) stores win_wdata in that byte.
- R6: A stack pointer write (code 13) always stores the value with bit 0 cleared.
- R7: cond_sel codes C=2, NC=3, Z=4, NZ=5, H=6, NH=7 use carry (status bit 0) and zero (status bit 6): C is carry, NC is not carry, Z is zero, NZ is not zero, H is true when neither is set, NH is true when either is set. The result appears on cond_true one cycle later.
- R8: cond_sel code T=0 is true when cond_val is nonzero, and code F=1 is true when cond_val is zero.
- R9: A read of a register in the same cycle that writes it returns the value from before the write.
- R10: When the window port and a selector write hit the same byte in the same cycle, the selector write's data is stored.
- R11: A write with selector 0 or any code above 18 changes no register, and a read with such a selector returns zero.
- R12: CS (15), ES (16), mode byte (17) and memory-bank byte (18) store wr_data[7:0] and read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel | input | 5 | Read register selector |
| rd_data | output | 16 | Registered read result |
| wr_en | input | 1 | Selector write enable |
| wr_sel | input | 5 | Write register selector |
| wr_data | input | 16 | Write data |
| win_addr | input | 5 | Flat window byte address |
| win_we | input | 1 | Window write enable |
| win_wdata | input | 8 | Window write data |
| win_rdata | output | 8 | Registered window read byte |
| cond_sel | input | 3 | Branch condition code |
| cond_val | input | 16 | Test value for conditions T and F |
| cond_true | output | 1 | Registered condition result |

## Verification
The bench builds the block with its default parameters: four banks, a reset byte of 0x11 and the stated status and segment reset values. With four banks every bank-select combination of the status word can be reached. This lets each bank's reversed window offset be confirmed by writing through a selector in one bank and reading the byte back through the window. Moving the status word between all four banks also shows that a status write and a read in the same cycle still see the old bank.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  localparam int REGS_PER_BANK = 8;
  localparam int SEL_W         = 5;

  // Status word bit positions
  localparam int ST_CY   = 0;
  localparam int ST_ISP0 = 1;
  localparam int ST_ISP1 = 2;
  localparam int ST_BNK0 = 3;
  localparam int ST_AC   = 4;
  localparam int ST_BNK1 = 5;
  localparam int ST_ZF   = 6;
  localparam int ST_IE   = 7;

  typedef enum logic [SEL_W-1:0] {
    SEL_NONE = 5'd0,
    SEL_X    = 5'd1,
    SEL_A    = 5'd2,
    SEL_C    = 5'd3,
    SEL_B    = 5'd4,
    SEL_E    = 5'd5,
    SEL_D    = 5'd6,
    SEL_L    = 5'd7,
    SEL_H    = 5'd8,
    SEL_AX   = 5'd9,
    SEL_BC   = 5'd10,
    SEL_DE   = 5'd11,
    SEL_HL   = 5'd12,
    SEL_SP   = 5'd13,
    SEL_ST   = 5'd14,
    SEL_CSEG = 5'd15,
    SEL_ESEG = 5'd16,
    SEL_MODE = 5'd17,
    SEL_MBNK = 5'd18
  } reg_sel_e;

  typedef enum logic [2:0] {
    CND_T  = 3'd0,
    CND_F  = 3'd1,
    CND_C  = 3'd2,
    CND_NC = 3'd3,
    CND_Z  = 3'd4,
    CND_NZ = 3'd5,
    CND_H  = 3'd6,
    CND_NH = 3'd7
  } cond_e;

  typedef struct packed {
    logic       hit_lo;
    logic       hit_hi;
    logic [2:0] lo_pos;
    logic [2:0] hi_pos;
  } gpr_map_t;

  // Maps a selector onto in-bank byte positions
  function automatic gpr_map_t gpr_decode(logic [SEL_W-1:0] sel);
    gpr_map_t m;
    logic [SEL_W-1:0] off;
    m   = '0;
    off = '0;
    if (sel >= 5'(SEL_X) && sel <= 5'(SEL_H)) begin
      off      = sel - 5'(SEL_X);
      m.hit_lo = 1'b1;
      m.lo_pos = off[2:0];
    end else if (sel >= 5'(SEL_AX) && sel <= 5'(SEL_HL)) begin
      off      = sel - 5'(SEL_AX);
      m.hit_lo = 1'b1;
      m.hit_hi = 1'b1;
      m.lo_pos = {off[1:0], 1'b0};
      m.hi_pos = {off[1:0], 1'b1};
    end
    return m;
  endfunction

endpackage

// File: rtl/rf_gpr_array.sv
module rf_gpr_array #(
  parameter int       NUM_BYTES = 32,
  parameter logic [7:0] INIT    = 8'h11,
  localparam int      AW        = $clog2(NUM_BYTES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      lo_we,
  input  logic [AW-1:0]             lo_idx,
  input  logic [7:0]                lo_data,
  input  logic                      hi_we,
  input  logic [AW-1:0]             hi_idx,
  input  logic [7:0]                hi_data,
  input  logic                      win_we,
  input  logic [AW-1:0]             win_idx,
  input  logic [7:0]                win_data,
  output logic [NUM_BYTES-1:0][7:0] bytes_o
);

  // Selector writes take priority over the window port per byte
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BYTES; i++) bytes_o[i] <= INIT;
    end else begin
      for (int i = 0; i < NUM_BYTES; i++) begin
        if (lo_we && lo_idx == AW'(i))
          bytes_o[i] <= lo_data;
        else if (hi_we && hi_idx == AW'(i))
          bytes_o[i] <= hi_data;
        else if (win_we && win_idx == AW'(i))
          bytes_o[i] <= win_data;
      end
    end
  end

  // Checker shadow: remember a colliding selector write
  logic          col_vld;
  logic [AW-1:0] col_idx;
  logic [7:0]    col_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_vld  <= 1'b0;
      col_idx  <= '0;
      col_data <= '0;
    end else begin
      col_vld  <= win_we && lo_we && (win_idx == lo_idx);
      col_idx  <= lo_idx;
      col_data <= lo_data;
    end
  end

  // R10
  named_beats_window_chk: assert property (@(posedge clk) disable iff (rst)
    col_vld |-> bytes_o[col_idx] == col_data);

  // R3
  pair_high_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (hi_we && lo_we && hi_idx != lo_idx) |=> bytes_o[$past(hi_idx)] == $past(hi_data));

endmodule

// File: rtl/rf_special_regs.sv
module rf_special_regs
  import regfile_pkg::*;
#(
  parameter logic [7:0] ST_INIT   = 8'h06,
  parameter logic [7:0] ESEG_INIT = 8'h0F,
  parameter logic [7:0] CSEG_INIT = 8'h00,
  parameter logic [7:0] MODE_INIT = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [15:0]      wr_data,
  output logic [7:0]       st_o,
  output logic [15:0]      sp_o,
  output logic [7:0]       cseg_o,
  output logic [7:0]       eseg_o,
  output logic [7:0]       mode_o,
  output logic [7:0]       mbnk_o
);

  logic [7:0] sp_lo_q, sp_hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_o    <= ST_INIT;
      sp_lo_q <= 8'h00;
      sp_hi_q <= 8'h00;
      cseg_o  <= CSEG_INIT;
      eseg_o  <= ESEG_INIT;
      mode_o  <= MODE_INIT;
      mbnk_o  <= 8'h00;
    end else if (wr_en) begin
      case (wr_sel)
        5'(SEL_ST):   st_o    <= wr_data[7:0];
        5'(SEL_SP): begin
          sp_lo_q <= {wr_data[7:1], 1'b0};
          sp_hi_q <= wr_data[15:8];
        end
        5'(SEL_CSEG): cseg_o  <= wr_data[7:0];
        5'(SEL_ESEG): eseg_o  <= wr_data[7:0];
        5'(SEL_MODE): mode_o  <= wr_data[7:0];
        5'(SEL_MBNK): mbnk_o  <= wr_data[7:0];
        default: ;
      endcase
    end
  end

  assign sp_o = {sp_hi_q, sp_lo_q};

  // R1
  special_reset_chk: assert property (@(posedge clk)
    rst |=> (st_o == ST_INIT && eseg_o == ESEG_INIT && cseg_o == CSEG_INIT
             && mode_o == MODE_INIT && sp_o == 16'h0000));

  // R6
  sp_even_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 5'(SEL_SP)) |=> sp_o == ($past(wr_data) & 16'hFFFE));

  // R12
  cseg_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 5'(SEL_CSEG)) |=> cseg_o == $past(wr_data[7:0]));

endmodule

// File: rtl/rf_cond_eval.sv
module rf_cond_eval
  import regfile_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       st,
  input  logic [2:0]       cond_sel,
  input  logic [VAL_W-1:0] cond_val,
  output logic             cond_true
);

  logic cy, zf, res;

  assign cy = st[ST_CY];
  assign zf = st[ST_ZF];

  always_comb begin
    case (cond_e'(cond_sel))
      CND_T:   res = |cond_val;
      CND_F:   res = ~|cond_val;
      CND_C:   res = cy;
      CND_NC:  res = ~cy;
      CND_Z:   res = zf;
      CND_NZ:  res = ~zf;
      CND_H:   res = ~(zf | cy);
      CND_NH:  res = zf | cy;
      default: res = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cond_true <= 1'b0;
    else     cond_true <= res;
  end

  // R7
  cond_higher_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 3'(CND_H)) |=> cond_true == !($past(st[ST_ZF]) || $past(st[ST_CY])));

  // R7
  cond_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 3'(CND_C)) |=> cond_true == $past(st[ST_CY]));

  // R8
  cond_test_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 3'(CND_T)) |=> cond_true == ($past(cond_val) != '0));

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import regfile_pkg::*;
#(
  parameter int         NUM_BANKS = 4,
  parameter logic [7:0] GPR_INIT  = 8'h11,
  parameter logic [7:0] ST_INIT   = 8'h06,
  parameter logic [7:0] ESEG_INIT = 8'h0F,
  parameter logic [7:0] CSEG_INIT = 8'h00,
  parameter logic [7:0] MODE_INIT = 8'h00,
  localparam int        NUM_BYTES = NUM_BANKS * REGS_PER_BANK,
  localparam int        AW        = $clog2(NUM_BYTES),
  localparam int        BW        = $clog2(NUM_BANKS)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  rd_sel,
  output logic [15:0] rd_data,
  input  logic        wr_en,
  input  logic [4:0]  wr_sel,
  input  logic [15:0] wr_data,
  input  logic [4:0]  win_addr,
  input  logic        win_we,
  input  logic [7:0]  win_wdata,
  output logic [7:0]  win_rdata,
  input  logic [2:0]  cond_sel,
  input  logic [15:0] cond_val,
  output logic        cond_true
);

  logic [NUM_BYTES-1:0][7:0] gpr;
  logic [7:0]  st, cseg, eseg, mode, mbnk;
  logic [15:0] sp;
  logic [BW-1:0] bank;

  // Bank number from the two status select bits
  assign bank = BW'({st[ST_BNK1], st[ST_BNK0]});

  // Banks are laid out top-down in the flat window
  function automatic logic [AW-1:0] phys(logic [BW-1:0] bk, logic [2:0] pos);
    return AW'((NUM_BANKS - 1 - int'(bk)) * REGS_PER_BANK) + AW'(pos);
  endfunction

  gpr_map_t wmap, rmap;
  assign wmap = gpr_decode(wr_sel);
  assign rmap = gpr_decode(rd_sel);

  logic          lo_we, hi_we;
  logic [AW-1:0] lo_idx, hi_idx, rlo_idx, rhi_idx;

  assign lo_we   = wr_en & wmap.hit_lo;
  assign hi_we   = wr_en & wmap.hit_hi;
  assign lo_idx  = phys(bank, wmap.lo_pos);
  assign hi_idx  = phys(bank, wmap.hi_pos);
  assign rlo_idx = phys(bank, rmap.lo_pos);
  assign rhi_idx = phys(bank, rmap.hi_pos);

  rf_gpr_array #(
    .NUM_BYTES (NUM_BYTES),
    .INIT      (GPR_INIT)
  ) u_gpr (
    .clk      (clk),
    .rst      (rst),
    .lo_we    (lo_we),
    .lo_idx   (lo_idx),
    .lo_data  (wr_data[7:0]),
    .hi_we    (hi_we),
    .hi_idx   (hi_idx),
    .hi_data  (wr_data[15:8]),
    .win_we   (win_we),
    .win_idx  (AW'(win_addr)),
    .win_data (win_wdata),
    .bytes_o  (gpr)
  );

  rf_special_regs #(
    .ST_INIT   (ST_INIT),
    .ESEG_INIT (ESEG_INIT),
    .CSEG_INIT (CSEG_INIT),
    .MODE_INIT (MODE_INIT)
  ) u_special (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .st_o    (st),
    .sp_o    (sp),
    .cseg_o  (cseg),
    .eseg_o  (eseg),
    .mode_o  (mode),
    .mbnk_o  (mbnk)
  );

  rf_cond_eval #(
    .VAL_W (16)
  ) u_cond (
    .clk       (clk),
    .rst       (rst),
    .st        (st),
    .cond_sel  (cond_sel),
    .cond_val  (cond_val),
    .cond_true (cond_true)
  );

  // Read mux; registered so reads see pre-write state
  logic [15:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (rmap.hit_hi)
      rd_next = {gpr[rhi_idx], gpr[rlo_idx]};
    else if (rmap.hit_lo)
      rd_next = {8'h00, gpr[rlo_idx]};
    else begin
      case (rd_sel)
        5'(SEL_SP):   rd_next = sp;
        5'(SEL_ST):   rd_next = {8'h00, st};
        5'(SEL_CSEG): rd_next = {8'h00, cseg};
        5'(SEL_ESEG): rd_next = {8'h00, eseg};
        5'(SEL_MODE): rd_next = {8'h00, mode};
        5'(SEL_MBNK): rd_next = {8'h00, mbnk};
        default:      rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      win_rdata <= '0;
    end else begin
      rd_data   <= rd_next;
      win_rdata <= gpr[AW'(win_addr)];
    end
  end

  // R11
  undefined_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == 5'(SEL_NONE) || rd_sel > 5'(SEL_MBNK)) |=> rd_data == 16'h0000);

  // R4
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 5'(SEL_ST)) |=> bank == BW'({$past(wr_data[ST_BNK1]), $past(wr_data[ST_BNK0])}));

endmodule

// File: tb/test_bank_regfile.sv
module test_bank_regfile;

  localparam int CLK_PERIOD = 10;

  localparam logic [4:0] S_NONE = 5'd0,  S_X = 5'd1,  S_A = 5'd2,  S_C = 5'd3;
  localparam logic [4:0] S_B    = 5'd4,  S_D = 5'd6,  S_L = 5'd7,  S_H = 5'd8;
  localparam logic [4:0] S_AX   = 5'd9,  S_HL = 5'd12, S_SP = 5'd13, S_ST = 5'd14;
  localparam logic [4:0] S_CS   = 5'd15, S_ES = 5'd16, S_MODE = 5'd17, S_MB = 5'd18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  win_addr = '0;
  logic        win_we = 1'b0;
  logic [7:0]  win_wdata = '0;
  logic [7:0]  win_rdata;
  logic [2:0]  cond_sel = '0;
  logic [15:0] cond_val = '0;
  logic        cond_true;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_regfile i_bank_regfile (
    .clk       (clk),
    .rst       (rst),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .win_addr  (win_addr),
    .win_we    (win_we),
    .win_wdata (win_wdata),
    .win_rdata (win_rdata),
    .cond_sel  (cond_sel),
    .cond_val  (cond_val),
    .cond_true (cond_true)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  // One cycle: optional write, read of rs; returns read result
  task automatic step(input logic [4:0] rs, input logic we, input logic [4:0] ws,
                      input logic [15:0] wd, output logic [15:0] rv);
    rd_sel = rs; wr_en = we; wr_sel = ws; wr_data = wd;
    @(negedge clk);
    rv = rd_data;
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [4:0] ws, input logic [15:0] wd);
    logic [15:0] dummy;
    step(S_NONE, 1'b1, ws, wd, dummy);
  endtask

  task automatic rd_chk(input string req, input logic [4:0] rs, input logic [15:0] exp);
    logic [15:0] v;
    step(rs, 1'b0, S_NONE, 16'h0, v);
    check(req, v, exp);
  endtask

  task automatic win_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    win_addr = a;
    @(negedge clk);
    check(req, {8'h00, win_rdata}, {8'h00, exp});
  endtask

  task automatic cond_chk(input string req, input logic [2:0] c, input logic [15:0] v,
                          input logic exp);
    cond_sel = c; cond_val = v;
    @(negedge clk);
    check(req, {15'h0, cond_true}, {15'h0, exp});
  endtask

  task automatic t_reset;
    rd_chk("R1 A reset", S_A, 16'h0011);
    rd_chk("R1 HL reset", S_HL, 16'h1111);
    rd_chk("R1 status reset", S_ST, 16'h0006);
    rd_chk("R1 ES reset", S_ES, 16'h000F);
    rd_chk("R1 CS reset", S_CS, 16'h0000);
    rd_chk("R1 mode reset", S_MODE, 16'h0000);
    rd_chk("R1 SP reset", S_SP, 16'h0000);
    win_chk("R1 window byte 0 reset", 5'd0, 8'h11);
  endtask

  task automatic t_bytes;
    wr(S_ST, 16'h0000);
    wr(S_A, 16'hFF5A);
    wr(S_X, 16'h00C3);
    rd_chk("R2 A byte", S_A, 16'h005A);
    rd_chk("R3 AX pair read", S_AX, 16'h5AC3);
    win_chk("R5 bank0 A at 25", 5'd25, 8'h5A);
    win_chk("R5 bank0 X at 24", 5'd24, 8'hC3);
  endtask

  task automatic t_pairs;
    wr(S_HL, 16'hBEEF);
    rd_chk("R3 H from pair", S_H, 16'h00BE);
    rd_chk("R3 L from pair", S_L, 16'h00EF);
    win_chk("R5 bank0 H at 31", 5'd31, 8'hBE);
    win_chk("R5 bank0 L at 30", 5'd30, 8'hEF);
  endtask

  task automatic t_banks;
    logic [15:0] v;
    // status write and read in same cycle still use old bank
    step(S_A, 1'b1, S_ST, 16'h0008, v);
    check("R4 read in status-write cycle uses old bank", v, 16'h005A);
    rd_chk("R4 bank1 A fresh", S_A, 16'h0011);
    wr(S_B, 16'h0077);
    win_chk("R5 bank1 B at 19", 5'd19, 8'h77);
    wr(S_ST, 16'h0020);
    wr(S_C, 16'h0044);
    win_chk("R5 bank2 C at 10", 5'd10, 8'h44);
    wr(S_ST, 16'h0028);
    wr(S_D, 16'h0099);
    win_chk("R5 bank3 D at 5", 5'd5, 8'h99);
    rd_chk("R4 bank3 B untouched", S_B, 16'h0011);
    wr(S_ST, 16'h0000);
    rd_chk("R4 back to bank0 AX", S_AX, 16'h5AC3);
  endtask

  task automatic t_sp;
    wr(S_SP, 16'h1235);
    rd_chk("R6 odd SP cleared", S_SP, 16'h1234);
    wr(S_SP, 16'hFFFF);
    rd_chk("R6 SP all ones", S_SP, 16'hFFFE);
  endtask

  task automatic t_rdw;
    logic [15:0] v;
    step(S_A, 1'b1, S_A, 16'h0012, v);
    check("R9 read during write returns old", v, 16'h005A);
    rd_chk("R9 new value after", S_A, 16'h0012);
  endtask

  task automatic t_collision;
    win_we = 1'b1; win_addr = 5'd25; win_wdata = 8'hEE;
    wr(S_A, 16'h0034);
    win_we = 1'b0;
    win_chk("R10 named write wins", 5'd25, 8'h34);
    win_we = 1'b1; win_addr = 5'd26; win_wdata = 8'h66;
    @(negedge clk);
    win_we = 1'b0;
    rd_chk("R5 window write seen as C", S_C, 16'h0066);
  endtask

  task automatic t_undefined;
    wr(S_NONE, 16'hFFFF);
    wr(5'd19, 16'hFFFF);
    wr(5'd31, 16'hFFFF);
    rd_chk("R11 AX unchanged", S_AX, 16'h34C3);
    rd_chk("R11 HL unchanged", S_HL, 16'hBEEF);
    rd_chk("R11 status unchanged", S_ST, 16'h0000);
    rd_chk("R11 SP unchanged", S_SP, 16'hFFFE);
    rd_chk("R11 MB unchanged", S_MB, 16'h0000);
    rd_chk("R11 read sel 0 zero", S_NONE, 16'h0000);
    rd_chk("R11 read sel 20 zero", 5'd20, 16'h0000);
  endtask

  task automatic t_special;
    wr(S_CS, 16'h1234);
    rd_chk("R12 CS low byte", S_CS, 16'h0034);
    wr(S_ES, 16'hAB07);
    rd_chk("R12 ES low byte", S_ES, 16'h0007);
    wr(S_MODE, 16'h00A5);
    rd_chk("R12 mode byte", S_MODE, 16'h00A5);
    wr(S_MB, 16'h5502);
    rd_chk("R12 memory bank byte", S_MB, 16'h0002);
  endtask

  task automatic t_cond;
    wr(S_ST, 16'h0000);
    cond_chk("R7 C clear", 3'd2, 16'h0, 1'b0);
    cond_chk("R7 NC clear", 3'd3, 16'h0, 1'b1);
    cond_chk("R7 Z clear", 3'd4, 16'h0, 1'b0);
    cond_chk("R7 NZ clear", 3'd5, 16'h0, 1'b1);
    cond_chk("R7 H clear", 3'd6, 16'h0, 1'b1);
    cond_chk("R7 NH clear", 3'd7, 16'h0, 1'b0);
    wr(S_ST, 16'h0041);
    cond_chk("R7 C set", 3'd2, 16'h0, 1'b1);
    cond_chk("R7 Z set", 3'd4, 16'h0, 1'b1);
    cond_chk("R7 H both", 3'd6, 16'h0, 1'b0);
    wr(S_ST, 16'h0001);
    cond_chk("R7 NH carry only", 3'd7, 16'h0, 1'b1);
    cond_chk("R7 NZ carry only", 3'd5, 16'h0, 1'b1);
    wr(S_ST, 16'h0040);
    cond_chk("R7 H zero only", 3'd6, 16'h0, 1'b0);
    cond_chk("R8 T nonzero", 3'd0, 16'h0100, 1'b1);
    cond_chk("R8 F nonzero", 3'd1, 16'h0100, 1'b0);
    cond_chk("R8 T zero", 3'd0, 16'h0000, 1'b0);
    cond_chk("R8 F zero", 3'd1, 16'h0000, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bytes();
    t_pairs();
    t_banks();
    t_sp();
    t_rdw();
    t_collision();
    t_undefined();
    t_special();
    t_cond();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule